// File: doc/BRIEF.md
# Tagged Multi-Source Capture FIFO

This block gathers bytes from twelve producers into one shared queue: six serial sensor channels, two 32-bit encoder counters, a snapshot of four digital inputs, a snapshot of six receive-line states and two 16-bit converters. Each queue entry is 16 bits wide. The low byte carries data. The high byte is a tag that names the source class, the channel within that class and the position of the byte inside a multi-byte value. A host drains the queue one entry per pop, watches a fill count, and receives two threshold flags for its interrupt logic.

Each producer raises a one-cycle request with its value. A per-source holding slot keeps the value until the shared write port takes it. A fixed-priority arbiter serves the slots. Once a multi-byte value has started, the arbiter finishes it without letting another source in between. A 16-bit enable word switches each source on or off. Its top four bits decide whether each of the four external inputs, while high, blocks a group of sources. When the queue is full, a new entry overwrites the oldest one, so the queue always holds the newest data.

Top module: `tagged_capture_fifo`

## Requirements
- R1: Every entry holds its data byte in bits 7:0. Bits 15:14 give the class (00 sensor, 01 encoder, 10 input snapshot, 11 converter), bits 13:11 the channel (sensor n is channel n-1, encoder n and converter n are channel n-1), and bits 10:8 the byte index.
- R2: An encoder value is stored as four entries and a converter value as two, least significant byte first, with byte index 0, 1, 2, 3. No entry from another source is placed between the bytes of one value.
- R3: The external-input snapshot uses channel 0 with data {4'b0, ext_in}. The receive-line snapshot uses channel 1 with data {2'b0, rxd_state}.
- R4: Enable bits 0-5 control sensors 1-6, bits 6-7 encoders 1-2, bit 8 the external-input snapshot, bit 9 the receive-line snapshot, and bits 10-11 converters 1-2. A request from a disabled source is ignored.
- R5: While enable bit 12 is 0, a high ext_in[0] blocks sensors 1-2. Bit 13 with ext_in[1] likewise blocks sensors 3-6, bit 14 with ext_in[2] blocks both encoders, and bit 15 with ext_in[3] blocks both converters and both snapshots. A bit at 1 makes its input have no effect.
- R6: Requests pending in the same cycle are stored in order of source index, lowest first. The index order is sensors 1-6, encoders 1-2, input snapshot, receive-line snapshot, converters 1-2.
- R7: A request seen at one clock edge is counted in fill_level after the next edge. The fill level changes by at most one per cycle unless a clear occurs.
- R8: fill_level gives the entry count in bits 14:0, and bit 15 is always 0.
- R9: The count never exceeds DEPTH. A write into a full queue drops the oldest entry and keeps the count at DEPTH.
- R10: flag_half is 1 exactly when the count is above DEPTH/2, and flag_3q exactly when it is above 3*DEPTH/4.
- R11: A one-cycle clear empties the queue. The count reads 0 after the next edge.
- R12: A pop returns the oldest entry on rd_data after the next edge. A pop of an empty queue returns 0 and leaves the count at 0.
- R13: After reset the count is 0, both flags are 0 and rd_data is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| src_enable | input | 16 | Per-source enables (11:0) and gate masks (15:12) |
| ext_in | input | 4 | External inputs, high means active |
| sen_req | input | 6 | Sensor byte requests, one per channel |
| sen_byte | input | 48 | Sensor bytes, channel n at bits 8n+7:8n |
| enc_req | input | 2 | Encoder value requests |
| enc_value | input | 64 | Encoder values, 32 bits each |
| in_snap_req | input | 1 | Request to store an ext_in snapshot |
| rxd_snap_req | input | 1 | Request to store a receive-line snapshot |
| rxd_state | input | 6 | Receive-line levels |
| adc_req | input | 2 | Converter sample requests |
| adc_value | input | 32 | Converter samples, 16 bits each |
| clear | input | 1 | Flush the queue |
| rd_pop | input | 1 | Host pop strobe |
| rd_data | output | 16 | Popped entry |
| fill_level | output | 16 | Entry count |
| flag_half | output | 1 | Count above half depth |
| flag_3q | output | 1 | Count above three-quarter depth |

## Verification
A bad head or tail pointer shows up at the first pop after the fault: the wrong byte comes out, or the tag of another source appears. A bad count shows up as soon as fill_level or a flag is read after the next edge. A slot that releases its hold too early splits a multi-byte value. The byte indices on the popped entries then run out of order, or a foreign tag lands between them. A gating or enable fault changes the count two edges after the request that should have been ignored.

// File: rtl/tcf_pkg.sv
package tcf_pkg;
  localparam int NSEN  = 6;
  localparam int NENC  = 2;
  localparam int NADC  = 2;
  localparam int NSRC  = NSEN + NENC + 2 + NADC;
  localparam int VALW  = 32;
  localparam int ENTW  = 16;

  localparam int IDX_ENC  = NSEN;
  localparam int IDX_INSN = NSEN + NENC;
  localparam int IDX_RXSN = IDX_INSN + 1;
  localparam int IDX_ADC  = IDX_RXSN + 1;

  typedef enum logic [1:0] {
    CLS_SENSOR = 2'b00,
    CLS_ENC    = 2'b01,
    CLS_SNAP   = 2'b10,
    CLS_ADC    = 2'b11
  } src_class_e;

  function automatic logic [1:0] src_class(input int i);
    if (i < IDX_ENC)       return CLS_SENSOR;
    else if (i < IDX_INSN) return CLS_ENC;
    else if (i < IDX_ADC)  return CLS_SNAP;
    else                   return CLS_ADC;
  endfunction

  function automatic logic [2:0] src_chan(input int i);
    if (i < IDX_ENC)       return 3'(i);
    else if (i < IDX_INSN) return 3'(i - IDX_ENC);
    else if (i < IDX_ADC)  return 3'(i - IDX_INSN);
    else                   return 3'(i - IDX_ADC);
  endfunction

  function automatic int src_nbytes(input int i);
    if (i >= IDX_ENC && i < IDX_INSN) return 4;
    else if (i >= IDX_ADC)            return 2;
    else                              return 1;
  endfunction

  // gate group: 0 sensors 1-2, 1 sensors 3-6, 2 encoders, 3 converters+snapshots
  function automatic int src_group(input int i);
    if (i < 2)             return 0;
    else if (i < IDX_ENC)  return 1;
    else if (i < IDX_INSN) return 2;
    else                   return 3;
  endfunction
endpackage

// File: rtl/tcf_slot.sv
module tcf_slot #(
  parameter int         NBYTES = 1,
  parameter logic [1:0] CLS    = 2'b00,
  parameter logic [2:0] CHAN   = 3'd0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_ok,
  input  logic [31:0] value,
  input  logic        grant,
  output logic        pend,
  output logic        mid,
  output logic [15:0] entry
);
  localparam logic [2:0] LAST = 3'(NBYTES - 1);

  logic [31:0] hold_q;
  logic        full_q, full_d;
  logic [2:0]  bidx_q, bidx_d;
  logic        last, take;

  assign last = (bidx_q == LAST);
  assign take = req_ok && (!full_q || (grant && last));

  always_comb begin
    full_d = full_q;
    bidx_d = bidx_q;
    if (grant) begin
      if (last) begin
        full_d = 1'b0;
        bidx_d = 3'd0;
      end else begin
        bidx_d = bidx_q + 3'd1;
      end
    end
    if (take) begin
      full_d = 1'b1;
      bidx_d = 3'd0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      bidx_q <= 3'd0;
      hold_q <= '0;
    end else begin
      full_q <= full_d;
      bidx_q <= bidx_d;
      if (take) hold_q <= value;
    end
  end

  logic [31:0] shifted;
  assign shifted = hold_q >> {bidx_q, 3'b000};
  assign entry   = {CLS, CHAN, bidx_q, shifted[7:0]};
  assign pend    = full_q;
  assign mid     = full_q && (bidx_q != 3'd0);
endmodule

// File: rtl/tcf_arbiter.sv
module tcf_arbiter #(
  parameter int N = 12
) (
  input  logic [N-1:0] pend,
  input  logic [N-1:0] mid,
  output logic [N-1:0] grant
);
  logic any_mid;

  always_comb begin
    grant   = '0;
    any_mid = |mid;
    if (any_mid) begin
      for (int i = N - 1; i >= 0; i--)
        if (mid[i]) grant = N'(1) << i;
    end else begin
      for (int i = N - 1; i >= 0; i--)
        if (pend[i]) grant = N'(1) << i;
    end
  end
endmodule

// File: rtl/tcf_ring.sv
module tcf_ring #(
  parameter int DEPTH = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        push,
  input  logic [15:0] push_entry,
  input  logic        pop,
  input  logic        clear,
  output logic [15:0] rd_data,
  output logic [$clog2(DEPTH):0] count,
  output logic        flag_half,
  output logic        flag_3q
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;
  localparam logic [CW-1:0] FULLC = CW'(DEPTH);
  localparam logic [CW-1:0] HALFC = CW'(DEPTH / 2);
  localparam logic [CW-1:0] TQC   = CW'((DEPTH * 3) / 4);

  logic [15:0]   mem [DEPTH];
  logic [AW-1:0] head_q, head_d, tail_q, tail_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [15:0]   rd_q, rd_d;
  logic          full, do_pop, do_push;

  assign full    = (cnt_q == FULLC);
  assign do_pop  = pop && (cnt_q != '0) && !clear;
  assign do_push = push && !clear;

  always_comb begin
    head_d = head_q;
    tail_d = tail_q;
    cnt_d  = cnt_q;
    rd_d   = rd_q;
    if (pop) rd_d = do_pop ? mem[head_q] : 16'h0000;
    if (clear) begin
      head_d = '0;
      tail_d = '0;
      cnt_d  = '0;
    end else begin
      if (do_pop || (do_push && full)) head_d = head_q + AW'(1);
      if (do_push) tail_d = tail_q + AW'(1);
      if (do_push && !full && !do_pop)  cnt_d = cnt_q + CW'(1);
      else if (do_pop && !do_push)      cnt_d = cnt_q - CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
      rd_q   <= '0;
    end else begin
      head_q <= head_d;
      tail_q <= tail_d;
      cnt_q  <= cnt_d;
      rd_q   <= rd_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[tail_q] <= push_entry;
  end

  assign rd_data   = rd_q;
  assign count     = cnt_q;
  assign flag_half = (cnt_q > HALFC);
  assign flag_3q   = (cnt_q > TQC);
endmodule

// File: rtl/tagged_capture_fifo.sv
module tagged_capture_fifo #(
  parameter int DEPTH = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] src_enable,
  input  logic [3:0]  ext_in,
  input  logic [5:0]  sen_req,
  input  logic [47:0] sen_byte,
  input  logic [1:0]  enc_req,
  input  logic [63:0] enc_value,
  input  logic        in_snap_req,
  input  logic        rxd_snap_req,
  input  logic [5:0]  rxd_state,
  input  logic [1:0]  adc_req,
  input  logic [31:0] adc_value,
  input  logic        clear,
  input  logic        rd_pop,
  output logic [15:0] rd_data,
  output logic [15:0] fill_level,
  output logic        flag_half,
  output logic        flag_3q
);
  import tcf_pkg::*;

  localparam int CW = $clog2(DEPTH) + 1;

  // reset: asynchronous assert, synchronous release
  logic rst_meta, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  logic [NSRC-1:0] req, req_ok, pend, mid, grant;
  logic [31:0]     value [NSRC];
  logic [15:0]     entry [NSRC];
  logic [3:0]      gate;
  logic            push;
  logic [15:0]     push_entry;
  logic [CW-1:0]   count;

  always_comb begin
    for (int g = 0; g < 4; g++) gate[g] = ext_in[g] & ~src_enable[12 + g];
  end

  always_comb begin
    for (int i = 0; i < NSEN; i++) begin
      req[i]   = sen_req[i];
      value[i] = {24'h0, sen_byte[i*8 +: 8]};
    end
    for (int i = 0; i < NENC; i++) begin
      req[IDX_ENC + i]   = enc_req[i];
      value[IDX_ENC + i] = enc_value[i*32 +: 32];
    end
    req[IDX_INSN]   = in_snap_req;
    value[IDX_INSN] = {28'h0, ext_in};
    req[IDX_RXSN]   = rxd_snap_req;
    value[IDX_RXSN] = {26'h0, rxd_state};
    for (int i = 0; i < NADC; i++) begin
      req[IDX_ADC + i]   = adc_req[i];
      value[IDX_ADC + i] = {16'h0, adc_value[i*16 +: 16]};
    end
  end

  for (genvar s = 0; s < NSRC; s++) begin : g_slot
    assign req_ok[s] = req[s] & src_enable[s] & ~gate[src_group(s)];
    tcf_slot #(
      .NBYTES(src_nbytes(s)),
      .CLS   (src_class(s)),
      .CHAN  (src_chan(s))
    ) u_slot (
      .clk   (clk),
      .rst_n (rst_sync_n),
      .req_ok(req_ok[s]),
      .value (value[s]),
      .grant (grant[s]),
      .pend  (pend[s]),
      .mid   (mid[s]),
      .entry (entry[s])
    );
  end

  tcf_arbiter #(.N(NSRC)) u_arb (
    .pend (pend),
    .mid  (mid),
    .grant(grant)
  );

  always_comb begin
    push_entry = 16'h0000;
    for (int i = 0; i < NSRC; i++)
      if (grant[i]) push_entry = push_entry | entry[i];
  end
  assign push = |grant;

  tcf_ring #(.DEPTH(DEPTH)) u_ring (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .push      (push),
    .push_entry(push_entry),
    .pop       (rd_pop),
    .clear     (clear),
    .rd_data   (rd_data),
    .count     (count),
    .flag_half (flag_half),
    .flag_3q   (flag_3q)
  );

  assign fill_level = {1'b0, 15'(count)};
endmodule

// File: rtl/tcf_checker.sv
module tcf_checker #(
  parameter int DEPTH = 64
) (
  input logic        clk,
  input logic        rst_sync_n,
  input logic        clear,
  input logic        rd_pop,
  input logic [15:0] rd_data,
  input logic [15:0] fill_level,
  input logic        flag_half,
  input logic        flag_3q,
  input logic [11:0] mid
);
  localparam logic [15:0] FULLV = 16'(DEPTH);

  assert_level_bound_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    fill_level <= FULLV);

  assert_full_hold_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (fill_level == FULLV && !rd_pop && !clear) |=> fill_level == FULLV);

  assert_flag_order_R10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    flag_3q |-> flag_half);

  assert_clear_R11: assert property (@(posedge clk) disable iff (!rst_sync_n)
    clear |=> fill_level == 16'd0);

  assert_empty_read_R12: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rd_pop && fill_level == 16'd0) |=> rd_data == 16'h0000);

  assert_level_step_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !clear |=> (fill_level == $past(fill_level) ||
                fill_level == $past(fill_level) + 16'd1 ||
                fill_level == $past(fill_level) - 16'd1));

  assert_single_burst_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $onehot0(mid));
endmodule

bind tagged_capture_fifo tcf_checker #(.DEPTH(DEPTH)) u_tcf_checker (
  .clk       (clk),
  .rst_sync_n(rst_sync_n),
  .clear     (clear),
  .rd_pop    (rd_pop),
  .rd_data   (rd_data),
  .fill_level(fill_level),
  .flag_half (flag_half),
  .flag_3q   (flag_3q),
  .mid       (mid)
);

// File: tb/tagged_capture_fifo_bench.sv
`timescale 1ns/1ps
module tagged_capture_fifo_bench;
  localparam int DEPTH = 64;

  logic        clk;
  logic        rst_n;
  logic [15:0] src_enable;
  logic [3:0]  ext_in;
  logic [5:0]  sen_req;
  logic [47:0] sen_byte;
  logic [1:0]  enc_req;
  logic [63:0] enc_value;
  logic        in_snap_req, rxd_snap_req;
  logic [5:0]  rxd_state;
  logic [1:0]  adc_req;
  logic [31:0] adc_value;
  logic        clear, rd_pop;
  logic [15:0] rd_data, fill_level;
  logic        flag_half, flag_3q;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  tagged_capture_fifo #(.DEPTH(DEPTH)) u_tagged_capture_fifo (
    .clk(clk), .rst_n(rst_n), .src_enable(src_enable), .ext_in(ext_in),
    .sen_req(sen_req), .sen_byte(sen_byte), .enc_req(enc_req),
    .enc_value(enc_value), .in_snap_req(in_snap_req),
    .rxd_snap_req(rxd_snap_req), .rxd_state(rxd_state), .adc_req(adc_req),
    .adc_value(adc_value), .clear(clear), .rd_pop(rd_pop), .rd_data(rd_data),
    .fill_level(fill_level), .flag_half(flag_half), .flag_3q(flag_3q)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic sen_push(input int ch, input logic [7:0] b);
    @(negedge clk);
    sen_req[ch] = 1'b1;
    sen_byte[ch*8 +: 8] = b;
    @(negedge clk);
    sen_req[ch] = 1'b0;
    idle(2);
  endtask

  task automatic pop(output logic [15:0] v);
    @(negedge clk);
    rd_pop = 1'b1;
    @(negedge clk);
    rd_pop = 1'b0;
    v = rd_data;
  endtask

  task automatic t_reset;
    check("R13 level", 32'(fill_level), 0);
    check("R13 flags", {30'h0, flag_half, flag_3q}, 0);
    check("R13 rd_data", 32'(rd_data), 0);
  endtask

  task automatic t_sensor_tag;
    logic [15:0] v;
    sen_push(2, 8'hA5);
    check("R7 level after one request", 32'(fill_level), 1);
    check("R8 level msb", 32'(fill_level[15]), 0);
    pop(v);
    check("R1 sensor 3 entry", 32'(v), 32'h10A5);
    check("R12 level after pop", 32'(fill_level), 0);
  endtask

  task automatic t_priority;
    logic [15:0] v;
    @(negedge clk);
    sen_req[0] = 1'b1; sen_byte[7:0] = 8'h11;
    sen_req[4] = 1'b1; sen_byte[39:32] = 8'h44;
    @(negedge clk);
    sen_req = '0;
    idle(3);
    check("R6 level", 32'(fill_level), 2);
    pop(v);
    check("R6 first served", 32'(v), 32'h0011);
    pop(v);
    check("R6 second served", 32'(v), 32'h2044);
  endtask

  task automatic t_encoder_burst;
    logic [15:0] v;
    @(negedge clk);
    enc_req[1] = 1'b1; enc_value[63:32] = 32'h11223344;
    @(negedge clk);
    enc_req = '0;
    sen_req[0] = 1'b1; sen_byte[7:0] = 8'h77;
    @(negedge clk);
    sen_req = '0;
    idle(5);
    check("R2 level after burst", 32'(fill_level), 5);
    pop(v); check("R2 encoder byte 0", 32'(v), 32'h4844);
    pop(v); check("R2 encoder byte 1", 32'(v), 32'h4933);
    pop(v); check("R2 encoder byte 2", 32'(v), 32'h4A22);
    pop(v); check("R2 encoder byte 3", 32'(v), 32'h4B11);
    pop(v); check("R2 sensor after burst", 32'(v), 32'h0077);
  endtask

  task automatic t_adc_and_snap;
    logic [15:0] v;
    @(negedge clk);
    adc_req[1] = 1'b1; adc_value[31:16] = 16'hBEEF;
    @(negedge clk);
    adc_req = '0;
    idle(4);
    pop(v); check("R2 converter low byte", 32'(v), 32'hC8EF);
    pop(v); check("R2 converter high byte", 32'(v), 32'hC9BE);
    @(negedge clk);
    ext_in = 4'b0101; in_snap_req = 1'b1;
    @(negedge clk);
    in_snap_req = 1'b0; ext_in = 4'b0000;
    rxd_state = 6'h2D; rxd_snap_req = 1'b1;
    @(negedge clk);
    rxd_snap_req = 1'b0;
    idle(3);
    pop(v); check("R3 input snapshot", 32'(v), 32'h8005);
    pop(v); check("R3 receive-line snapshot", 32'(v), 32'h882D);
  endtask

  task automatic t_enable_gate;
    logic [15:0] v;
    src_enable = 16'hFFF7;
    sen_push(3, 8'h33);
    check("R4 disabled sensor ignored", 32'(fill_level), 0);
    src_enable = 16'h0FFF;
    ext_in = 4'b0001;
    sen_push(1, 8'h12);
    check("R5 IN1 blocks sensor 2", 32'(fill_level), 0);
    ext_in = 4'b0010;
    sen_push(5, 8'h56);
    check("R5 IN2 blocks sensor 6", 32'(fill_level), 0);
    ext_in = 4'b1000;
    @(negedge clk); adc_req[0] = 1'b1;
    @(negedge clk); adc_req = '0;
    idle(4);
    check("R5 IN4 blocks converter", 32'(fill_level), 0);
    src_enable = 16'hFFFF;
    ext_in = 4'b0011;
    sen_push(1, 8'h9C);
    check("R5 mask bit set lets sensor through", 32'(fill_level), 1);
    pop(v);
    check("R5 passed entry", 32'(v), 32'h089C);
    ext_in = 4'b0000;
  endtask

  task automatic t_fill_overwrite;
    logic [15:0] v;
    for (int i = 0; i < DEPTH + 3; i++) begin
      sen_push(0, 8'(i));
      if (i + 1 == DEPTH / 2)      check("R10 half flag at half", 32'(flag_half), 0);
      if (i + 1 == DEPTH / 2 + 1)  check("R10 half flag above half", 32'(flag_half), 1);
      if (i + 1 == DEPTH * 3 / 4)  check("R10 3q flag at 3/4", 32'(flag_3q), 0);
      if (i + 1 == DEPTH * 3 / 4 + 1) check("R10 3q flag above 3/4", 32'(flag_3q), 1);
    end
    check("R9 level saturates", 32'(fill_level), DEPTH);
    pop(v);
    check("R9 oldest kept is fourth", 32'(v), 32'h0003);
    @(negedge clk); clear = 1'b1;
    @(negedge clk); clear = 1'b0;
    check("R11 level after clear", 32'(fill_level), 0);
    check("R11 flags after clear", {30'h0, flag_half, flag_3q}, 0);
    pop(v);
    check("R12 empty pop returns zero", 32'(v), 0);
    check("R12 empty pop keeps level", 32'(fill_level), 0);
  endtask

  initial begin
    rst_n = 1'b0;
    src_enable = 16'hFFFF; ext_in = '0;
    sen_req = '0; sen_byte = '0; enc_req = '0; enc_value = '0;
    in_snap_req = 1'b0; rxd_snap_req = 1'b0; rxd_state = '0;
    adc_req = '0; adc_value = '0; clear = 1'b0; rd_pop = 1'b0;
    idle(3);
    rst_n = 1'b1;
    idle(4);
    t_reset;
    t_sensor_tag;
    t_priority;
    t_encoder_burst;
    t_adc_and_snap;
    t_enable_gate;
    t_fill_overwrite;
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule